// File: doc/BRIEF.md
# Floating-Point NaN Screen

This block sits in front of a floating-point execution unit. It looks at up to three operands in either single or double precision and sorts each one into ordinary number, signaling NaN or quiet NaN. From these classes, the operation class and the invalid-exception enable, it reaches one of three verdicts:

- `VD_PASS`: the datapath result stands.
- `VD_QUIET`: the result is replaced by the canonical quiet NaN.
- `VD_TRAP`: an invalid-operation exception is raised and the destination write is blocked.

The convention is the inverted one. A fraction MSB of 1 marks a signaling NaN. The substituted quiet NaN has that bit clear.

The verdict is formed combinationally. With the default `REG_OUT = 1` it is captured in an output register, so results appear one clock after the inputs. The verdict is an enumerated decision, not a stored state machine. There are no transitions: each cycle's verdict depends only on that cycle's inputs.

Top module: `nan_screen`

## Requirements
- R1: While `rst_n` is low, `ovr_valid`, `inv_flag` and `wr_en` are 0 and `ovr_value` is all zeros.
- R2: An operand is a NaN only when its exponent field is all ones and its fraction is non-zero. The sign bit is ignored. An infinity (all-ones exponent, zero fraction) is not a NaN and causes no override.
- R3: A NaN is signaling when its fraction MSB is 1 and quiet when it is 0. That bit is bit 51 in double precision and bit 22 in single precision.
- R4: For `op_kind` = 0 (arithmetic), if any used operand is a signaling NaN and `inv_en` = 0, then `ovr_valid` = 1, `inv_flag` = 0 and `wr_en` = 1.
- R5: For `op_kind` = 0, if any used operand is a signaling NaN and `inv_en` = 1, then `inv_flag` = 1, `wr_en` = 0 and `ovr_valid` = 0. This holds even when a quiet NaN is also present.
- R6: For `op_kind` = 0, if a quiet NaN is present and no signaling NaN is present, then `ovr_valid` = 1, `inv_flag` = 0 and `wr_en` = 1, whatever the value of `inv_en`.
- R7: For `op_kind` = 1 (transfer), 2 (absolute value) or 3 (negate), the outputs are `ovr_valid` = 0, `inv_flag` = 0 and `wr_en` = 1, even with signaling NaN operands.
- R8: When `ovr_valid` = 1, `ovr_value` is 0x7FF7FFFFFFFFFFFF for double precision (`dbl` = 1) and 0x000000007FBFFFFF for single precision. When `ovr_valid` = 0, `ovr_value` is zero.
- R9: An operand whose `opnd_used` bit is 0 is never classified as a NaN. The bit order is: bit 0 for `opnd_a`, bit 1 for `opnd_b`, bit 2 for `opnd_c`.
- R10: Outputs reflect the inputs sampled at the previous rising clock edge, a latency of one cycle.
- R11: In single precision only the low 32 bits of each operand are examined. In double precision a single-precision NaN pattern in the low half alone is an ordinary number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| opnd_a | input | 64 | Operand 0 |
| opnd_b | input | 64 | Operand 1 |
| opnd_c | input | 64 | Operand 2 |
| opnd_used | input | 3 | Per-operand valid mask |
| dbl | input | 1 | 1 = double precision, 0 = single precision |
| op_kind | input | 2 | 0 arithmetic, 1 transfer, 2 absolute, 3 negate |
| inv_en | input | 1 | Invalid-operation exception enable |
| ovr_valid | output | 1 | Result must be replaced by `ovr_value` |
| ovr_value | output | 64 | Canonical quiet NaN, or zero |
| inv_flag | output | 1 | Invalid-operation exception |
| wr_en | output | 1 | Destination register write permitted |

## Verification
Arithmetic operations are tried with five kinds of operand:
- Ordinary numbers and infinities, which separate a real NaN from a value that only has an all-ones exponent.
- Signaling and quiet NaNs in both precisions and under both enable settings, which separate the substitute, trap and quiet-pass verdicts.
- A mixed quiet/signaling set, which checks that the signaling NaN takes priority.

The exempt operation classes are then driven with signaling NaNs. Masked slots carry NaNs, and precision-mismatched patterns (junk in the upper half, or a single NaN inside a double) confirm that only the right fields are decoded.

// File: rtl/nanscr_pkg.sv
package nanscr_pkg;

    localparam int OPND_W = 64;

    typedef enum logic [1:0] {
        OPK_ARITH = 2'd0,
        OPK_XFER  = 2'd1,
        OPK_ABS   = 2'd2,
        OPK_NEG   = 2'd3
    } opk_e;

    typedef enum logic [1:0] {
        VD_PASS  = 2'd0,
        VD_QUIET = 2'd1,
        VD_TRAP  = 2'd2
    } verdict_e;

endpackage

// File: rtl/nanscr_classify.sv
module nanscr_classify #(
    parameter int W      = 64,
    parameter int D_EXP  = 11,
    parameter int D_FRAC = 52,
    parameter int S_EXP  = 8,
    parameter int S_FRAC = 23
) (
    input  logic [W-1:0] opnd,
    input  logic         used,
    input  logic         dbl,
    output logic         is_snan,
    output logic         is_qnan
);
    localparam int D_FMSB = D_FRAC - 1;
    localparam int S_FMSB = S_FRAC - 1;
    localparam int S_SGN  = S_FRAC + S_EXP;
    localparam int D_SGN  = D_FRAC + D_EXP;

    logic [D_EXP-1:0]  d_exp;
    logic [D_FRAC-1:0] d_frac;
    logic [S_EXP-1:0]  s_exp;
    logic [S_FRAC-1:0] s_frac;
    logic              exp_ones;
    logic              frac_nz;
    logic              sig_bit;
    logic              is_nan;
    logic              unused_sign;

    assign d_exp  = opnd[D_FRAC +: D_EXP];
    assign d_frac = opnd[D_FRAC-1:0];
    assign s_exp  = opnd[S_FRAC +: S_EXP];
    assign s_frac = opnd[S_FRAC-1:0];

    // sign bits take no part in classification
    assign unused_sign = ^{opnd[D_SGN], opnd[S_SGN]};

    always_comb begin
        if (dbl) begin
            exp_ones = &d_exp;
            frac_nz  = |d_frac;
            sig_bit  = d_frac[D_FMSB];
        end else begin
            exp_ones = &s_exp;
            frac_nz  = |s_frac;
            sig_bit  = s_frac[S_FMSB];
        end
    end

    assign is_nan  = used && exp_ones && frac_nz;
    assign is_snan = is_nan && sig_bit;
    assign is_qnan = is_nan && !sig_bit;

    // R2: an infinity is never reported as any NaN
    always_comb begin
        if (exp_ones && !frac_nz)
            a_inf_r2: assert (!is_snan && !is_qnan);
    end
endmodule

// File: rtl/nanscr_decide.sv
module nanscr_decide
    import nanscr_pkg::*;
#(
    parameter int              N      = 3,
    parameter int              W      = 64,
    parameter int              S_W    = 32,
    parameter logic [W-1:0]    D_QNAN = 64'h7FF7_FFFF_FFFF_FFFF,
    parameter logic [S_W-1:0]  S_QNAN = 32'h7FBF_FFFF
) (
    input  logic [N-1:0] snan_v,
    input  logic [N-1:0] qnan_v,
    input  logic         dbl,
    input  logic [1:0]   op_kind,
    input  logic         inv_en,
    output logic         ovr_v,
    output logic [W-1:0] ovr_val,
    output logic         inv,
    output logic         we
);
    localparam logic [W-1:0] S_QNAN_EXT = {{(W-S_W){1'b0}}, S_QNAN};

    verdict_e vd;
    logic     any_s;
    logic     any_q;

    assign any_s = |snan_v;
    assign any_q = |qnan_v;

    always_comb begin
        vd = VD_PASS;
        if (opk_e'(op_kind) == OPK_ARITH) begin
            if (any_s)
                vd = inv_en ? VD_TRAP : VD_QUIET;
            else if (any_q)
                vd = VD_QUIET;
        end
    end

    always_comb begin
        ovr_v   = 1'b0;
        ovr_val = '0;
        inv     = 1'b0;
        we      = 1'b1;
        unique case (vd)
            VD_PASS: begin
                ovr_v = 1'b0;
            end
            VD_QUIET: begin
                ovr_v   = 1'b1;
                ovr_val = dbl ? D_QNAN : S_QNAN_EXT;
            end
            VD_TRAP: begin
                inv = 1'b1;
                we  = 1'b0;
            end
            default: begin
                ovr_v = 1'b0;
            end
        endcase
    end

    // R7: a non-arithmetic class never leaves the pass verdict
    always_comb begin
        if (opk_e'(op_kind) != OPK_ARITH)
            a_exempt_r7: assert (!ovr_v && !inv && we);
    end
endmodule

// File: rtl/nan_screen.sv
module nan_screen
    import nanscr_pkg::*;
#(
    parameter int N_OPND  = 3,
    parameter int D_EXP   = 11,
    parameter int D_FRAC  = 52,
    parameter int S_EXP   = 8,
    parameter int S_FRAC  = 23,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [OPND_W-1:0]     opnd_a,
    input  logic [OPND_W-1:0]     opnd_b,
    input  logic [OPND_W-1:0]     opnd_c,
    input  logic [N_OPND-1:0]     opnd_used,
    input  logic                  dbl,
    input  logic [1:0]            op_kind,
    input  logic                  inv_en,
    output logic                  ovr_valid,
    output logic [OPND_W-1:0]     ovr_value,
    output logic                  inv_flag,
    output logic                  wr_en
);
    localparam int S_W = S_EXP + S_FRAC + 1;
    localparam logic [OPND_W-1:0] D_QNAN = 64'h7FF7_FFFF_FFFF_FFFF;
    localparam logic [OPND_W-1:0] S_QNAN = 64'h0000_0000_7FBF_FFFF;

    logic [OPND_W-1:0] opnd_arr [N_OPND];
    logic [N_OPND-1:0] snan_v;
    logic [N_OPND-1:0] qnan_v;
    logic              c_ovr;
    logic [OPND_W-1:0] c_val;
    logic              c_inv;
    logic              c_we;

    assign opnd_arr[0] = opnd_a;
    assign opnd_arr[1] = opnd_b;
    assign opnd_arr[2] = opnd_c;

    for (genvar i = 0; i < N_OPND; i++) begin : g_cls
        nanscr_classify #(
            .W(OPND_W), .D_EXP(D_EXP), .D_FRAC(D_FRAC),
            .S_EXP(S_EXP), .S_FRAC(S_FRAC)
        ) u_cls (
            .opnd    (opnd_arr[i]),
            .used    (opnd_used[i]),
            .dbl     (dbl),
            .is_snan (snan_v[i]),
            .is_qnan (qnan_v[i])
        );
    end

    nanscr_decide #(
        .N(N_OPND), .W(OPND_W), .S_W(S_W),
        .D_QNAN(D_QNAN), .S_QNAN(S_QNAN[S_W-1:0])
    ) u_dec (
        .snan_v  (snan_v),
        .qnan_v  (qnan_v),
        .dbl     (dbl),
        .op_kind (op_kind),
        .inv_en  (inv_en),
        .ovr_v   (c_ovr),
        .ovr_val (c_val),
        .inv     (c_inv),
        .we      (c_we)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ovr_valid <= 1'b0;
                ovr_value <= '0;
                inv_flag  <= 1'b0;
                wr_en     <= 1'b0;
            end else begin
                ovr_valid <= c_ovr;
                ovr_value <= c_val;
                inv_flag  <= c_inv;
                wr_en     <= c_we;
            end
        end

        p_trap_nowr_r5: assert property (@(posedge clk) disable iff (!rst_n)
            inv_flag |-> !wr_en);
        p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(inv_flag && ovr_valid));
        p_canon_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ovr_valid |-> (ovr_value == D_QNAN || ovr_value == S_QNAN));
        p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !ovr_valid |-> (ovr_value == '0));
        p_exempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (op_kind != 2'd0) |=> (!ovr_valid && !inv_flag && wr_en));
        p_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (opnd_used == '0) |=> (!ovr_valid && !inv_flag));
        p_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (op_kind == 2'd0 && inv_en && (|snan_v)) |=> (inv_flag && !wr_en));
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign ovr_valid  = c_ovr;
        assign ovr_value  = c_val;
        assign inv_flag   = c_inv;
        assign wr_en      = c_we;
    end
endmodule

// File: tb/sim_nan_screen.sv
module sim_nan_screen;
    localparam logic [63:0] DQ = 64'h7FF7_FFFF_FFFF_FFFF;
    localparam logic [63:0] SQ = 64'h0000_0000_7FBF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
    logic [2:0]  opnd_used = '0;
    logic        dbl = 1'b0;
    logic [1:0]  op_kind = '0;
    logic        inv_en = 1'b0;
    logic        ovr_valid, inv_flag, wr_en;
    logic [63:0] ovr_value;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic        ov;
        logic [63:0] val;
        logic        inv;
        logic        we;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #2 clk = ~clk;

    nan_screen u0 (
        .clk(clk), .rst_n(rst_n),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .opnd_used(opnd_used), .dbl(dbl), .op_kind(op_kind), .inv_en(inv_en),
        .ovr_valid(ovr_valid), .ovr_value(ovr_value),
        .inv_flag(inv_flag), .wr_en(wr_en)
    );

    task automatic compare(input exp_t e);
        n_checks++;
        if (ovr_valid !== e.ov || ovr_value !== e.val ||
            inv_flag !== e.inv || wr_en !== e.we) begin
            n_errors++;
            $display("FAIL %s: ov=%0b/%0b val=%h/%h inv=%0b/%0b we=%0b/%0b",
                     e.tag, ovr_valid, e.ov, ovr_value, e.val,
                     inv_flag, e.inv, wr_en, e.we);
        end
    endtask

    // driver: apply at falling edge, expected result due after next rising edge (R10)
    task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                         input logic [2:0] used, input logic d, input logic [1:0] k,
                         input logic en, input logic eov, input logic [63:0] eval,
                         input logic einv, input logic ewe, input string tag);
        exp_t e;
        @(negedge clk);
        opnd_a = a; opnd_b = b; opnd_c = c;
        opnd_used = used; dbl = d; op_kind = k; inv_en = en;
        e.ov = eov; e.val = eval; e.inv = einv; e.we = ewe; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && sb_q.size() > 0) compare(sb_q.pop_front());
        end
    end

    localparam logic [63:0] D_ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] D_INF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] D_SNAN = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] D_QNAN = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] S_SNAN = 64'h0000_0000_FFC0_0000;
    localparam logic [63:0] S_QNAN = 64'h0000_0000_7F80_0001;
    localparam logic [63:0] S_INF  = 64'h0000_0000_7F80_0000;

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        r.ov = 0; r.val = '0; r.inv = 0; r.we = 0; r.tag = "R1 reset";
        compare(r);
        @(negedge clk);
        rst_n = 1'b1;

        drive(D_ONE, D_ONE, D_INF, 3'b111, 1, 0, 1, 0, '0, 0, 1, "R2 numbers and infinity");
        drive(S_INF, S_INF, S_INF, 3'b111, 0, 0, 1, 0, '0, 0, 1, "R2 single infinity");
        drive(D_SNAN, D_ONE, D_ONE, 3'b111, 1, 0, 0, 1, DQ, 0, 1, "R4 R3 R10 double snan en0");
        drive(D_SNAN, D_ONE, D_ONE, 3'b111, 1, 0, 1, 0, '0, 1, 0, "R5 double snan en1");
        drive(D_ONE, D_QNAN, D_ONE, 3'b111, 1, 0, 1, 1, DQ, 0, 1, "R6 R3 qnan en1");
        drive(D_ONE, D_ONE, D_QNAN, 3'b111, 1, 0, 0, 1, DQ, 0, 1, "R6 qnan en0");
        drive(D_ONE, S_SNAN, D_ONE, 3'b111, 0, 0, 0, 1, SQ, 0, 1, "R4 R8 R2 single snan neg sign");
        drive(S_QNAN, S_SNAN, '0, 3'b111, 0, 0, 1, 0, '0, 1, 0, "R5 mixed snan priority");
        drive(S_QNAN, '0, '0, 3'b001, 0, 0, 0, 1, SQ, 0, 1, "R8 single qnan value");
        drive(D_SNAN, '0, '0, 3'b001, 1, 1, 1, 0, '0, 0, 1, "R7 transfer");
        drive(D_SNAN, '0, '0, 3'b001, 1, 2, 1, 0, '0, 0, 1, "R7 absolute");
        drive(S_SNAN, '0, '0, 3'b001, 0, 3, 0, 0, '0, 0, 1, "R7 negate");
        drive(D_ONE, D_ONE, D_SNAN, 3'b011, 1, 0, 1, 0, '0, 0, 1, "R9 masked snan");
        drive(D_QNAN, D_QNAN, D_QNAN, 3'b000, 1, 0, 0, 0, '0, 0, 1, "R9 all masked");
        drive(64'hFFFF_FFFF_3F80_0000, '0, '0, 3'b111, 0, 0, 1, 0, '0, 0, 1, "R11 upper junk");
        drive(64'h7FF8_0000_0000_0000, '0, '0, 3'b001, 0, 0, 1, 0, '0, 0, 1, "R11 double snan seen single");
        drive(64'h0000_0000_7FC0_0000, '0, '0, 3'b001, 1, 0, 1, 0, '0, 0, 1, "R11 single nan seen double");
        drive(D_ONE, '0, '0, 3'b001, 1, 0, 0, 0, '0, 0, 1, "R10 back to pass");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: expired got=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule